// File: doc/BRIEF.md
# External Reference Source Switch

This block chooses the reference input of a clock-synchronizer front end when an external switching mode is enabled. A single board-level select pin picks one of two candidate source pairs. Within the chosen pair, the programmed priority of the single-ended input decides which input is used. A non-zero priority selects the single-ended input. A zero priority redirects the choice to the differential partner of the same pair. The forced choice never looks at whether a signal is present on the chosen input. While the mode is on, the block reports that the operating mode is forced to locked.

When the mode is off, the block passes through, registered, the source index produced by an external automatic selector. The mode enable bit lives in a one-bit register. Its reset value is the level of the select pin during reset, and software can rewrite it afterwards with a write strobe. The select pin is asynchronous to the block clock and passes through a synchronizer before it is used. Every change of the selected index raises a one-cycle change pulse.

Top module: `ext_ref_switch`

## Requirements
- R1: While `rst_n` is low, `mode_en` takes the level of `sw_pin` at each clock edge, `src_idx` is 0 and `src_chg` is 0.
- R2: A clock edge with `cfg_wr` high loads `cfg_wdata` into `mode_en`. Without `cfg_wr`, `mode_en` holds its value.
- R3: Index encoding: 0 = pair-1 single-ended, 1 = pair-1 differential, 2 = pair-2 single-ended, 3 = pair-2 differential. With the mode on and the synchronized pin high, `src_idx` becomes 0 if `pri_s1_se` is non-zero and 1 if it is zero.
- R4: With the mode on and the synchronized pin low, `src_idx` becomes 2 if `pri_s2_se` is non-zero and 3 if it is zero.
- R5: With the mode on, `auto_idx` has no effect on `src_idx`.
- R6: With the mode off, `src_idx` equals the `auto_idx` value from the previous cycle.
- R7: `force_locked` is high exactly when `mode_en` is high.
- R8: A change of `sw_pin` with the mode on first appears on `src_idx` at the third rising edge after the change. Two of those edges are synchronizer stages and one is the output register.
- R9: `src_chg` is high in exactly those cycles in which `src_idx` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_pin | input | 1 | Asynchronous external select pin |
| cfg_wr | input | 1 | Write strobe for the mode enable bit |
| cfg_wdata | input | 1 | Value written to the mode enable bit |
| pri_s1_se | input | PRI_W | Programmed priority of the pair-1 single-ended input |
| pri_s2_se | input | PRI_W | Programmed priority of the pair-2 single-ended input |
| auto_idx | input | 2 | Index from the external automatic selector |
| mode_en | output | 1 | Current value of the mode enable bit |
| force_locked | output | 1 | Operating mode forced to locked |
| src_idx | output | 2 | Selected source index |
| src_chg | output | 1 | One-cycle pulse when the selected index changes |

## Verification
A wrong mode bit shows at once on `mode_en` and `force_locked`. One cycle later it shows on `src_idx`, which then either follows `auto_idx` when it should not, or ignores it when it should follow it. A stale or skipped synchronizer stage moves the pin-driven switch of `src_idx` off the third edge after the pin change, so a check at each of the three edges exposes it within three cycles. A bad stored index shows as a `src_chg` pulse that does not match the index sequence on the next cycle.

// File: rtl/ext_ref_switch_pkg.sv
package ext_ref_switch_pkg;

    typedef enum logic [1:0] {
        SRC_P1_SE = 2'd0,
        SRC_P1_DF = 2'd1,
        SRC_P2_SE = 2'd2,
        SRC_P2_DF = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic     ext_en;
        src_sel_e idx;
        logic     chg;
    } sw_state_t;

endpackage

// File: rtl/ers_sync.sv
module ers_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    // reset preloads the pin level so leaving reset causes no false edge
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{din}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ers_pick.sv
module ers_pick
    import ext_ref_switch_pkg::*;
#(
    parameter int PRI_W = 4
) (
    input  logic             pin_hi,
    input  logic [PRI_W-1:0] pri_p1,
    input  logic [PRI_W-1:0] pri_p2,
    output src_sel_e         forced
);
    always_comb begin
        if (pin_hi) forced = (pri_p1 != '0) ? SRC_P1_SE : SRC_P1_DF;
        else        forced = (pri_p2 != '0) ? SRC_P2_SE : SRC_P2_DF;
    end
endmodule

// File: rtl/ext_ref_switch.sv
module ext_ref_switch
    import ext_ref_switch_pkg::*;
#(
    parameter int PRI_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_pin,
    input  logic             cfg_wr,
    input  logic             cfg_wdata,
    input  logic [PRI_W-1:0] pri_s1_se,
    input  logic [PRI_W-1:0] pri_s2_se,
    input  logic [1:0]       auto_idx,
    output logic             mode_en,
    output logic             force_locked,
    output logic [1:0]       src_idx,
    output logic             src_chg
);
    logic      sel_sync;
    src_sel_e  forced_sel;
    sw_state_t st_d, st_q;

    ers_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sw_pin),
        .dout  (sel_sync)
    );

    ers_pick #(.PRI_W(PRI_W)) u_pick (
        .pin_hi (sel_sync),
        .pri_p1 (pri_s1_se),
        .pri_p2 (pri_s2_se),
        .forced (forced_sel)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_wr) st_d.ext_en = cfg_wdata;
        st_d.idx = st_q.ext_en ? forced_sel : src_sel_e'(auto_idx);
        st_d.chg = (st_d.idx != st_q.idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ext_en <= sw_pin;
            st_q.idx    <= SRC_P1_SE;
            st_q.chg    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_en      = st_q.ext_en;
    assign force_locked = st_q.ext_en;
    assign src_idx      = st_q.idx;
    assign src_chg      = st_q.chg;
endmodule

// File: rtl/ers_chk.sv
module ers_chk #(
    parameter int PRI_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_wdata,
    input logic             sel_sync,
    input logic [PRI_W-1:0] pri_s1_se,
    input logic [PRI_W-1:0] pri_s2_se,
    input logic [1:0]       auto_idx,
    input logic             mode_en,
    input logic [1:0]       src_idx,
    input logic             src_chg
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(cfg_wr) |-> mode_en == $past(cfg_wdata));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(cfg_wr) |-> $stable(mode_en));

    p_pair1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_en) && $past(sel_sync)
        |-> src_idx == (($past(pri_s1_se) != '0) ? 2'd0 : 2'd1));

    p_pair2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(mode_en) && !$past(sel_sync)
        |-> src_idx == (($past(pri_s2_se) != '0) ? 2'd2 : 2'd3));

    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(mode_en) |-> src_idx == $past(auto_idx));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> src_chg == (src_idx != $past(src_idx)));
endmodule

bind ext_ref_switch ers_chk #(.PRI_W(PRI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .sel_sync  (sel_sync),
    .pri_s1_se (pri_s1_se),
    .pri_s2_se (pri_s2_se),
    .auto_idx  (auto_idx),
    .mode_en   (mode_en),
    .src_idx   (src_idx),
    .src_chg   (src_chg)
);

// File: tb/ext_ref_switch_bench.sv
module ext_ref_switch_bench;
    localparam int PRI_W = 4;
    localparam time CYC  = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_pin = 1'b0, cfg_wr = 1'b0, cfg_wdata = 1'b0;
    logic [PRI_W-1:0] pri_s1_se = '0, pri_s2_se = '0;
    logic [1:0] auto_idx = '0;
    logic mode_en, force_locked, src_chg;
    logic [1:0] src_idx;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    ext_ref_switch #(.PRI_W(PRI_W)) u_ext_ref_switch (
        .clk(clk), .rst_n(rst_n), .sw_pin(sw_pin), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .pri_s1_se(pri_s1_se), .pri_s2_se(pri_s2_se),
        .auto_idx(auto_idx), .mode_en(mode_en), .force_locked(force_locked),
        .src_idx(src_idx), .src_chg(src_chg)
    );

    function automatic logic [1:0] want_idx(input logic en, input logic pin,
                                            input logic [PRI_W-1:0] p1,
                                            input logic [PRI_W-1:0] p2,
                                            input logic [1:0] au);
        if (!en)      return au;
        else if (pin) return (p1 != 0) ? 2'd0 : 2'd1;
        else          return (p2 != 0) ? 2'd2 : 2'd3;
    endfunction

    // cycle model built from the requirements: pin history of two edges
    logic m_en, h1, h2, m_chg;
    logic [1:0] m_idx;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= sw_pin; h1 <= sw_pin; h2 <= sw_pin;
            m_idx <= 2'd0; m_chg <= 1'b0;
        end else begin
            logic [1:0] n;
            n = want_idx(m_en, h2, pri_s1_se, pri_s2_se, auto_idx);
            h1 <= sw_pin; h2 <= h1;
            if (cfg_wr) m_en <= cfg_wdata;
            m_chg <= (n != m_idx);
            m_idx <= n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset with pin high
        sw_pin = 1'b1; rst_n = 1'b0; auto_idx = 2'd3;
        step(3);
        chk("R1 mode_en", mode_en, 1);
        chk("R1 src_idx", src_idx, 0);
        chk("R1 src_chg", src_chg, 0);
        chk("R7 locked in reset", force_locked, 1);
        // R1: reset with pin low
        sw_pin = 1'b0;
        step(2);
        chk("R1 mode_en low pin", mode_en, 0);
        rst_n = 1'b1;
        step(2);
        chk("R7 locked off", force_locked, 0);
        // R2: write enable
        cfg_wr = 1'b1; cfg_wdata = 1'b1;
        step(1);
        cfg_wr = 1'b0; cfg_wdata = 1'b0;
        chk("R2 write 1", mode_en, 1);
        chk("R7 locked on", force_locked, 1);
        step(2);
        chk("R2 hold", mode_en, 1);
        // R4: pair 2
        pri_s1_se = 4'd5; pri_s2_se = 4'd0; sw_pin = 1'b0;
        step(4);
        chk("R4 zero prio -> diff", src_idx, 3);
        pri_s2_se = 4'd7;
        step(1);
        chk("R4 nonzero prio -> se", src_idx, 2);
        chk("R9 pulse on change", src_chg, 1);
        step(1);
        chk("R9 pulse drops", src_chg, 0);
        // R8: pin latency
        pri_s1_se = 4'd3; sw_pin = 1'b1;
        step(1);
        chk("R8 edge1 unchanged", src_idx, 2);
        step(1);
        chk("R8 edge2 unchanged", src_idx, 2);
        step(1);
        chk("R8 edge3 switched", src_idx, 0);
        chk("R9 pulse on pin switch", src_chg, 1);
        // R3: zero priority on pair 1
        pri_s1_se = 4'd0;
        step(1);
        chk("R3 zero prio -> diff", src_idx, 1);
        pri_s1_se = 4'd15;
        step(1);
        chk("R3 nonzero prio -> se", src_idx, 0);
        // R5: auto index ignored
        for (int i = 0; i < 8; i++) begin
            auto_idx = 2'(i);
            step(1);
            chk("R5 auto ignored idx", src_idx, 0);
            chk("R5 auto ignored chg", src_chg, 0);
        end
        // R6: normal mode pass-through
        cfg_wr = 1'b1; cfg_wdata = 1'b0;
        step(1);
        cfg_wr = 1'b0;
        chk("R2 write 0", mode_en, 0);
        step(1);
        for (int i = 0; i < 4; i++) begin
            auto_idx = 2'(3 - i);
            step(1);
            chk("R6 pass-through", src_idx, 3 - i);
        end
        // random phase against the cycle model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(9) == 0) begin cfg_wr = 1'b1; cfg_wdata = 1'($urandom); end
            else cfg_wr = 1'b0;
            if ($urandom_range(4) == 0) sw_pin = ~sw_pin;
            pri_s1_se = ($urandom_range(2) == 0) ? '0 : PRI_W'($urandom);
            pri_s2_se = ($urandom_range(2) == 0) ? '0 : PRI_W'($urandom);
            auto_idx  = 2'($urandom);
            step(1);
            chk("R2 random mode_en", mode_en, m_en);
            chk("R7 random locked", force_locked, m_en);
            chk("R3 R4 R5 R6 random idx", src_idx, m_idx);
            chk("R9 random pulse", src_chg, m_chg);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule